// File: doc/BRIEF.md
# Separate-Port Two-Word-Burst Synchronous SRAM Model

This block is a synthesizable, cycle-exact model of a synchronous SRAM. It has one data path for reads and another for writes, and both share a single address bus. One system clock runs at twice the memory clock rate. The block counts alternating half-cycles internally. Half-cycle A carries the read command and half-cycle B carries the write command. The model mirrors the memory clock level on `k_o`, which is high during half-cycle A.

Each accepted command moves a pair of 36-bit words. Word 0 maps to the even location `2*addr` and word 1 maps to the odd location `2*addr+1`. Read data comes back after a delay chosen by a mode input. In long mode the delay is two and a half memory cycles. In short mode it is one memory cycle. A valid flag marks the half-cycles that carry read data. Writes can mask individual 9-bit lanes. A read issued right after a write to the same address returns the merged new contents.

Top module: `qdrx_sram`

## Requirements
- R1: Half-cycles alternate, starting with A in the first cycle after reset. A read is accepted in an A cycle when `rd_sel_ni` is low, using `addr_i` from that cycle. A write is accepted in a B cycle when `wr_sel_ni` is low. A read and a write may both be accepted within one memory cycle, at different addresses.
- R2: Word 0 of a write is `wd_i`/`be_i` in the B cycle that carries the command. Word 1 is `wd_i`/`be_i` in the following A cycle, whatever the select inputs do in that cycle. The two words land at locations 2*addr and 2*addr+1.
- R3: In long mode, a read accepted in cycle c drives word 0 on `rd_o` in cycle c+5 and word 1 in cycle c+6.
- R4: In short mode, a read accepted in cycle c drives word 0 in cycle c+2 and word 1 in cycle c+3.
- R5: `rvalid_o` is high exactly in the cycles that carry read words. In all other cycles `rvalid_o` is low and `rd_o` is zero. Reads issued back to back give a continuous run of valid cycles.
- R6: `be_i[k]` high writes bits 9k+8..9k of the word it accompanies. Lanes whose enable is low keep their old contents.
- R7: A read reflects every write accepted in an earlier memory cycle, including a write accepted in the B cycle directly before the read, with its lane masks applied. A write accepted after the read does not alter the read's data.
- R8: When a select input is high, its command is ignored. A dropped write leaves memory unchanged, and a dropped read produces no valid cycles.
- R9: `mode_i` (1 = long, 0 = short) is captured at the first clock edge after reset is released. Later changes have no effect until the next reset.
- R10: Reset clears all storage to zero and holds `rvalid_o` low and `rd_o` at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, twice the memory clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Latency select: 1 long, 0 short |
| k_o | output | 1 | Memory clock level, high in half-cycle A |
| addr_i | input | ADDR_W | Shared pair address |
| rd_sel_ni | input | 1 | Read select, active low, used in A cycles |
| wr_sel_ni | input | 1 | Write select, active low, used in B cycles |
| wd_i | input | 36 | Write data word |
| be_i | input | 4 | Lane write enables for the word on wd_i |
| rd_o | output | 36 | Read data word |
| rvalid_o | output | 1 | High while rd_o carries a read word |

## Verification
The bench builds the block with `ADDR_W = 3`, which gives eight pairs and sixteen words. At that size every location can be written, partly overwritten and read back in a short run. The run is split by a second reset, so both latency settings are exercised, and in each segment the mode input is toggled mid-run. Back-to-back reads, a read in the same memory cycle as a write, and a read directly after a write to the same pair all fit within a few memory cycles. This puts the overlap of the delay pipeline and the forwarding merge within reach.

// File: rtl/qdrx_pkg.sv
package qdrx_pkg;
  localparam int WORD_W = 36;
  localparam int LANE_W = 9;
  localparam int LANES  = WORD_W / LANE_W;
  localparam int LAT_XT = 5;  // long mode, half-cycles
  localparam int LAT_CP = 2;  // short mode, half-cycles

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [LANES-1:0]  lane_en_t;

  typedef struct packed {
    logic  v;
    word_t w0;
    word_t w1;
  } rd_slot_t;

  function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_en_t en);
    word_t res;
    for (int l = 0; l < LANES; l++)
      res[l*LANE_W +: LANE_W] = en[l] ? new_w[l*LANE_W +: LANE_W] : old_w[l*LANE_W +: LANE_W];
    return res;
  endfunction
endpackage

// File: rtl/qdrx_ctrl.sv
module qdrx_ctrl
  import qdrx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  word_t             wd_i,
  input  lane_en_t          be_i,
  output logic              phase_o,
  output logic              run_o,
  output logic              mode_o,
  output logic              rd_go_o,
  output logic              cmt_o,
  output logic [ADDR_W-1:0] cmt_addr_o,
  output word_t             cmt_w0_o,
  output lane_en_t          cmt_be0_o
);
  logic              phase_q, run_q, mode_q, pend_q;
  logic [ADDR_W-1:0] pend_a_q;
  word_t             pend_d_q;
  lane_en_t          pend_b_q;
  logic              wr_go;

  assign rd_go_o = !phase_q && !rd_sel_ni;
  assign wr_go   = phase_q && !wr_sel_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      mode_q  <= 1'b1;
    end else begin
      phase_q <= !phase_q;
      if (!run_q) begin
        run_q  <= 1'b1;
        mode_q <= mode_i;
      end
    end
  end

  // word 0 staged in B; committed with word 1 at end of next A
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= 1'b0;
      pend_a_q <= '0;
      pend_d_q <= '0;
      pend_b_q <= '0;
    end else begin
      pend_q <= wr_go;
      if (wr_go) begin
        pend_a_q <= addr_i;
        pend_d_q <= wd_i;
        pend_b_q <= be_i;
      end
    end
  end

  assign phase_o    = phase_q;
  assign run_o      = run_q;
  assign mode_o     = mode_q;
  assign cmt_o      = pend_q;
  assign cmt_addr_o = pend_a_q;
  assign cmt_w0_o   = pend_d_q;
  assign cmt_be0_o  = pend_b_q;
endmodule

// File: rtl/qdrx_store.sv
module qdrx_store
  import qdrx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  word_t [1:0]       wdata_i,
  input  lane_en_t [1:0]    wbe_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output word_t [1:0]       rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    word_t mem [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we_i) begin
        mem[waddr_i] <= lane_merge(mem[waddr_i], wdata_i[b], wbe_i[b]);
      end
    end

    assign rdata_o[b] = mem[raddr_i];
  end
endmodule

// File: rtl/qdrx_rpipe.sv
module qdrx_rpipe
  import qdrx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  mode_i,
  input  logic  load_i,
  input  word_t w0_i,
  input  word_t w1_i,
  output logic  valid_o,
  output word_t data_o
);
  localparam int DEPTH = LAT_XT + 1;

  rd_slot_t pipe [DEPTH];
  rd_slot_t tap0, tap1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= '{v: load_i, w0: w0_i, w1: w1_i};
      for (int i = 1; i < DEPTH; i++) pipe[i] <= pipe[i-1];
    end
  end

  always_comb begin
    tap0 = mode_i ? pipe[LAT_XT-1] : pipe[LAT_CP-1];
    tap1 = mode_i ? pipe[LAT_XT]   : pipe[LAT_CP];
    valid_o = tap0.v || tap1.v;
    if (tap0.v)      data_o = tap0.w0;
    else if (tap1.v) data_o = tap1.w1;
    else             data_o = '0;
  end
endmodule

// File: rtl/qdrx_sram.sv
module qdrx_sram
  import qdrx_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  output logic              k_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_sel_ni,
  input  logic              wr_sel_ni,
  input  logic [35:0]       wd_i,
  input  logic [3:0]        be_i,
  output logic [35:0]       rd_o,
  output logic              rvalid_o
);
  logic              phase, run_q, mode_q, rd_go, cmt;
  logic [ADDR_W-1:0] cmt_addr;
  word_t             cmt_w0, fw0, fw1;
  lane_en_t          cmt_be0;
  word_t [1:0]       st_rd;
  logic              hit;

  qdrx_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk_i, .rst_ni, .mode_i, .rd_sel_ni, .wr_sel_ni, .addr_i, .wd_i, .be_i,
    .phase_o(phase), .run_o(run_q), .mode_o(mode_q), .rd_go_o(rd_go),
    .cmt_o(cmt), .cmt_addr_o(cmt_addr), .cmt_w0_o(cmt_w0), .cmt_be0_o(cmt_be0)
  );

  qdrx_store #(.ADDR_W(ADDR_W)) u_store (
    .clk_i, .rst_ni,
    .we_i(cmt), .waddr_i(cmt_addr),
    .wdata_i({wd_i, cmt_w0}), .wbe_i({be_i, cmt_be0}),
    .raddr_i(addr_i), .rdata_o(st_rd)
  );

  // write committing at this edge is not yet in the array: merge it in
  assign hit = cmt && (cmt_addr == addr_i);
  assign fw0 = hit ? lane_merge(st_rd[0], cmt_w0, cmt_be0) : st_rd[0];
  assign fw1 = hit ? lane_merge(st_rd[1], wd_i, be_i) : st_rd[1];

  qdrx_rpipe u_rpipe (
    .clk_i, .rst_ni, .mode_i(mode_q), .load_i(rd_go),
    .w0_i(fw0), .w1_i(fw1), .valid_o(rvalid_o), .data_o(rd_o)
  );

  assign k_o = !phase;
endmodule

// File: rtl/qdrx_sram_chk.sv
module qdrx_sram_chk
  import qdrx_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_go_i,
  input logic        mode_i,
  input logic        run_i,
  input logic        rvalid_i,
  input logic [35:0] rdata_i
);
  logic acc;
  assign acc = rd_go_i && rst_ni;

  assert_long_lat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && ($past(acc, LAT_XT) || $past(acc, LAT_XT + 1))) |-> rvalid_i);

  assert_short_lat_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i && ($past(acc, LAT_CP) || $past(acc, LAT_CP + 1))) |-> rvalid_i);

  assert_valid_source_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_i |-> (mode_i ? ($past(acc, LAT_XT) || $past(acc, LAT_XT + 1))
                         : ($past(acc, LAT_CP) || $past(acc, LAT_CP + 1))));

  assert_idle_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rvalid_i |-> (rdata_i == '0));

  assert_mode_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(mode_i));
endmodule

bind qdrx_sram qdrx_sram_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_go_i(rd_go), .mode_i(mode_q),
  .run_i(run_q), .rvalid_i(rvalid_o), .rdata_i(rd_o)
);

// File: tb/qdrx_sram_test.sv
module qdrx_sram_test;
  localparam int AW = 3;

  logic clk = 1'b0, rst_n = 1'b0, mode = 1'b1;
  logic [AW-1:0] addr = '0;
  logic rsel_n = 1'b1, wsel_n = 1'b1;
  logic [35:0] wd = '0;
  logic [3:0] be = '0;
  logic k, rvalid;
  logic [35:0] rd;

  int nchk = 0, nbad = 0, cyc = 0;
  bit done = 0;
  string tag = "R10";

  logic [35:0] mem_m [int];
  logic [35:0] exp_d [int];
  bit mode_m = 1, pend = 0;
  int pa = 0;
  logic [35:0] pd0 = '0, nxt_w1 = '0;
  logic [3:0] pb0 = '0, nxt_b1 = '0;

  qdrx_sram #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .k_o(k), .addr_i(addr),
    .rd_sel_ni(rsel_n), .wr_sel_ni(wsel_n), .wd_i(wd), .be_i(be),
    .rd_o(rd), .rvalid_o(rvalid)
  );

  always #4 clk = !clk;

  function automatic logic [35:0] rd_word(int i);
    return mem_m.exists(i) ? mem_m[i] : 36'h0;
  endfunction

  function automatic void wr_word(int i, logic [35:0] d, logic [3:0] b);
    logic [35:0] w = rd_word(i);
    for (int l = 0; l < 4; l++) if (b[l]) w[l*9 +: 9] = d[l*9 +: 9];
    mem_m[i] = w;
  endfunction

  // reference model, one step per system cycle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; pend = 0; mem_m.delete(); exp_d.delete();
    end else begin
      int lat;
      if (cyc == 0) mode_m = mode;
      lat = mode_m ? 5 : 2;
      if (cyc % 2 == 0) begin
        if (pend) begin
          wr_word(2*pa, pd0, pb0);
          wr_word(2*pa + 1, wd, be);
        end
        pend = 0;
        if (!rsel_n) begin
          exp_d[cyc + lat]     = rd_word(2*int'(addr));
          exp_d[cyc + lat + 1] = rd_word(2*int'(addr) + 1);
        end
      end else begin
        pend = !wsel_n; pa = int'(addr); pd0 = wd; pb0 = be;
      end
      cyc++;
    end
  end

  task automatic chk(bit ev, logic [35:0] ed);
    nchk++;
    if (rvalid !== ev || rd !== ed) begin
      nbad++;
      $display("FAIL %s cycle %0d: actual valid=%0b data=%h expected valid=%0b data=%h",
               tag, cyc, rvalid, rd, ev, ed);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (exp_d.exists(cyc)) chk(1'b1, exp_d[cyc]);
      else chk(1'b0, 36'h0);
    end
  end

  // one memory cycle: A (read cmd + previous word 1), then B (write cmd + word 0)
  task automatic mcyc(bit do_rd, int ra, bit do_wr, int wa,
                      logic [35:0] w0, logic [3:0] b0, logic [35:0] w1, logic [3:0] b1);
    rsel_n = !do_rd; wsel_n = 1'b1; addr = AW'(ra); wd = nxt_w1; be = nxt_b1;
    @(negedge clk);
    rsel_n = 1'b1; wsel_n = !do_wr; addr = AW'(wa); wd = w0; be = b0;
    @(negedge clk);
    nxt_w1 = w1; nxt_b1 = b1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) mcyc(0, 0, 0, 0, 36'h0, 4'h0, 36'h0, 4'h0);
  endtask

  function automatic logic [35:0] pat(int i);
    return {4'(i), 32'h9E37_79B9 * 32'(i + 1)};
  endfunction

  task automatic do_reset(bit m);
    rst_n = 1'b0; mode = m; nxt_w1 = '0; nxt_b1 = '0;
    rsel_n = 1'b1; wsel_n = 1'b1; wd = 36'hF_FFFF_FFFF; be = 4'hF;
    tag = "R10";
    repeat (3) begin
      @(negedge clk);
      chk(1'b0, 36'h0);  // R10 outputs quiet in reset
    end
    rst_n = 1'b1;
  endtask

  task automatic run_suite(bit m);
    // R10: storage cleared by reset
    tag = "R10"; mcyc(1, 0, 0, 0, 0, 0, 0, 0); mcyc(1, 7, 0, 0, 0, 0, 0, 0); idle(4);
    // R2 R3 R4: fill every pair, then read back-to-back (R5 continuous valid)
    tag = m ? "R3" : "R4";
    for (int a = 0; a < 8; a++) mcyc(0, 0, 1, a, pat(2*a), 4'hF, pat(2*a+1), 4'hF);
    for (int a = 0; a < 8; a++) mcyc(1, a, 0, 0, 0, 0, 0, 0);
    idle(4);
    // R5: isolated reads with gaps
    tag = "R5"; mcyc(1, 2, 0, 0, 0, 0, 0, 0); idle(1); mcyc(1, 6, 0, 0, 0, 0, 0, 0); idle(4);
    // R6: lane masks
    tag = "R6";
    mcyc(0, 0, 1, 3, 36'hA_AAAA_AAAA, 4'b0101, 36'h5_5555_5555, 4'b1010);
    idle(1); mcyc(1, 3, 0, 0, 0, 0, 0, 0); idle(4);
    // R7: read before write in same memory cycle gets old; next cycle gets merged new
    tag = "R7";
    mcyc(1, 5, 1, 5, 36'h1_2345_6789, 4'b1100, 36'hF_EDCB_A987, 4'b0011);
    mcyc(1, 5, 0, 0, 0, 0, 0, 0); idle(4);
    // R1: read and write same memory cycle, different pairs
    tag = "R1";
    mcyc(1, 1, 1, 2, 36'h0_DEAD_BEEF, 4'hF, 36'h3_C0FF_EE00, 4'hF);
    mcyc(1, 2, 1, 1, 36'h7_0000_0001, 4'hF, 36'h7_0000_0002, 4'hF);
    mcyc(1, 1, 0, 0, 0, 0, 0, 0); idle(4);
    // R8: deselected write and read are ignored
    tag = "R8";
    mcyc(0, 0, 0, 0, 36'hF_FFFF_FFFF, 4'hF, 36'hF_FFFF_FFFF, 4'hF);
    idle(1); mcyc(1, 0, 0, 0, 0, 0, 0, 0); idle(4);
    // R9: mode pin change while running has no effect
    tag = "R9"; mode = !m;
    mcyc(1, 4, 0, 0, 0, 0, 0, 0); mcyc(1, 5, 0, 0, 0, 0, 0, 0); idle(4);
  endtask

  initial begin
    do_reset(1'b1);
    run_suite(1'b1);
    do_reset(1'b0);
    run_suite(1'b0);
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      nbad++; nchk++;
      $display("FAIL %s watchdog: actual=running expected=finished", tag);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule